// File: doc/BRIEF.md
# Microstate Control Sequencer

This block is the hardwired control unit of a small non-pipelined processor built around one shared bus. A state register walks through instruction fetch, a dispatch on the opcode held in the instruction register, and the execute microstates of each instruction. In every state it drives one control vector: which unit places a value on the bus, which registers capture it, the write enables for memory and the register file, the ALU function and the register-file port select. The control outputs are a pure function of the current state (Moore style), so each vector is valid for one full clock cycle.

The datapath supplies two inputs: the 4-bit opcode field of the instruction register and the latched zero flag. The opcode matters only on the edge that ends the third fetch state. The zero flag matters only on the edge that ends the branch test state. There is no streaming data interface: every pin is a plain control or status level, and there is no back-pressure.

Opcode codes: 0 add, 1 nand, 2 add-immediate, 3 load, 4 store, 5 branch-if-equal, 6 jump-and-link, 7 halt. Codes 8 to 15 are undefined. ALU function codes: 00 add, 01 nand, 10 subtract (A-B), 11 increment (A+1). Register select codes: 00 picks Rx, 01 picks Ry, 10 picks Rz. In any state where a strobe is not listed it is 0, and an unused `alu_fn` or `reg_sel` is driven 00.

Top module: `microseq_ctrl`

## Requirements
- R1: While `rst_n` is low the outputs show the first fetch state: `drv_pc`, `ld_mar` and `ld_a` high, everything else 0, `halted` 0.
- R2: Every instruction begins with three fetch cycles: (F1) `drv_pc`,`ld_mar`,`ld_a`; (F2) `drv_mem`,`ld_ir`; (F3) `drv_alu`,`ld_pc`, `alu_fn`=11.
- R3: At most one of `drv_pc`, `drv_alu`, `drv_reg`, `drv_mem`, `drv_off` is high in any cycle.
- R4: Opcode 0 (add) and opcode 1 (nand) run three cycles after fetch: `drv_reg`,`ld_a`,`reg_sel`=01; then `drv_reg`,`ld_b`,`reg_sel`=10; then `drv_alu`,`wr_reg`,`reg_sel`=00 with `alu_fn` 00 for add and 01 for nand.
- R5: Opcode 2 (add-immediate) runs: `drv_reg`,`ld_a`,`reg_sel`=01; then `drv_off`,`ld_b`; then `drv_alu`,`wr_reg`,`alu_fn`=00,`reg_sel`=00.
- R6: Opcode 3 (load) runs: `drv_reg`,`ld_a`,`reg_sel`=01; `drv_off`,`ld_b`; `drv_alu`,`ld_mar`,`alu_fn`=00; `drv_mem`,`wr_reg`,`reg_sel`=00.
- R7: Opcode 4 (store) runs the same three address cycles as load, then `drv_reg`,`wr_mem`,`reg_sel`=00.
- R8: Opcode 5 (branch) runs `drv_reg`,`ld_a`,`reg_sel`=00; `drv_reg`,`ld_b`,`reg_sel`=01; `drv_alu`,`ld_z`,`alu_fn`=10; then one test cycle with all strobes 0. If `zero` is 0 at the end of the test cycle, the next cycle is F1.
- R9: If `zero` is 1 at the end of the branch test cycle, three more cycles follow: `drv_pc`,`ld_a`; `drv_off`,`ld_b`; `drv_alu`,`ld_pc`,`alu_fn`=00. Then F1 follows.
- R10: Opcode 6 (jump-and-link) runs: `drv_pc`,`wr_reg`,`reg_sel`=01; then `drv_reg`,`ld_pc`,`reg_sel`=00. Then F1 follows.
- R11: Opcode 7 (halt) enters a state with `halted` 1 and all strobes 0. The block stays there whatever the inputs until `rst_n` goes low.
- R12: Opcodes 8 to 15 execute no microstates: F3 is followed directly by F1.
- R13: `opcode` has no effect except at the end of F3, and `zero` has no effect except at the end of the branch test cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to F1 |
| opcode | input | 4 | Opcode field from the instruction register |
| zero | input | 1 | Latched zero flag from the datapath |
| drv_pc | output | 1 | PC drives the bus |
| drv_alu | output | 1 | ALU result drives the bus |
| drv_reg | output | 1 | Register-file read port drives the bus |
| drv_mem | output | 1 | Memory read data drives the bus |
| drv_off | output | 1 | Sign-extended offset drives the bus |
| ld_pc | output | 1 | PC loads from the bus |
| ld_a | output | 1 | ALU operand A loads from the bus |
| ld_b | output | 1 | ALU operand B loads from the bus |
| ld_mar | output | 1 | Memory address register loads from the bus |
| ld_ir | output | 1 | Instruction register loads from the bus |
| ld_z | output | 1 | Zero flag loads from the ALU zero detect |
| wr_mem | output | 1 | Memory write enable |
| wr_reg | output | 1 | Register-file write enable |
| alu_fn | output | 2 | ALU function code |
| reg_sel | output | 2 | Register-file port select |
| halted | output | 1 | Sequencer is parked in the halt state |

## Verification
The embedded properties assume that reset is asserted before the first clock edge and that `zero` holds a clean 0 or 1 on the edge that ends the branch test cycle. They make no assumption about `opcode` or `zero` at any other time. The stimulus meets these conditions by driving both inputs only just after a rising edge, so each is settled long before the next edge. In the scrambled runs, inputs outside the two decision edges are inverted values, but they are always defined 0/1 levels.

// File: rtl/microseq_pkg.sv
package microseq_pkg;

  localparam int OPC_W = 4;
  localparam int FN_W  = 2;
  localparam int SEL_W = 2;
  localparam int ST_W  = 5;

  localparam logic [OPC_W-1:0] OP_ADD  = 4'd0;
  localparam logic [OPC_W-1:0] OP_NAND = 4'd1;
  localparam logic [OPC_W-1:0] OP_ADDI = 4'd2;
  localparam logic [OPC_W-1:0] OP_LW   = 4'd3;
  localparam logic [OPC_W-1:0] OP_SW   = 4'd4;
  localparam logic [OPC_W-1:0] OP_BEQ  = 4'd5;
  localparam logic [OPC_W-1:0] OP_JALR = 4'd6;
  localparam logic [OPC_W-1:0] OP_HALT = 4'd7;

  localparam logic [FN_W-1:0] FN_ADD  = 2'b00;
  localparam logic [FN_W-1:0] FN_NAND = 2'b01;
  localparam logic [FN_W-1:0] FN_SUB  = 2'b10;
  localparam logic [FN_W-1:0] FN_INC  = 2'b11;

  localparam logic [SEL_W-1:0] SEL_X = 2'b00;
  localparam logic [SEL_W-1:0] SEL_Y = 2'b01;
  localparam logic [SEL_W-1:0] SEL_Z = 2'b10;

  typedef enum logic [ST_W-1:0] {
    S_F1, S_F2, S_F3,
    S_ADD1, S_ADD2, S_ADD3,
    S_NAND1, S_NAND2, S_NAND3,
    S_ADDI1, S_ADDI2, S_ADDI3,
    S_LW1, S_LW2, S_LW3, S_LW4,
    S_SW1, S_SW2, S_SW3, S_SW4,
    S_BQ1, S_BQ2, S_BQ3, S_BQT, S_BQ4, S_BQ5, S_BQ6,
    S_JR1, S_JR2,
    S_HALT
  } mstate_t;

  typedef struct packed {
    logic             drv_pc;
    logic             drv_alu;
    logic             drv_reg;
    logic             drv_mem;
    logic             drv_off;
    logic             ld_pc;
    logic             ld_a;
    logic             ld_b;
    logic             ld_mar;
    logic             ld_ir;
    logic             ld_z;
    logic             wr_mem;
    logic             wr_reg;
    logic [FN_W-1:0]  alu_fn;
    logic [SEL_W-1:0] reg_sel;
  } ctrl_t;

endpackage

// File: rtl/microseq_next.sv
module microseq_next
  import microseq_pkg::*;
(
  input  mstate_t          cur,
  input  logic [OPC_W-1:0] opcode,
  input  logic             zero,
  output mstate_t          nxt
);

  // Dispatch from the last fetch state on the instruction's opcode.
  function automatic mstate_t dispatch(input logic [OPC_W-1:0] op);
    case (op)
      OP_ADD:  return S_ADD1;
      OP_NAND: return S_NAND1;
      OP_ADDI: return S_ADDI1;
      OP_LW:   return S_LW1;
      OP_SW:   return S_SW1;
      OP_BEQ:  return S_BQ1;
      OP_JALR: return S_JR1;
      OP_HALT: return S_HALT;
      default: return S_F1;      // undefined code behaves as a no-op
    endcase
  endfunction

  always_comb begin
    case (cur)
      S_F1:    nxt = S_F2;
      S_F2:    nxt = S_F3;
      S_F3:    nxt = dispatch(opcode);
      S_ADD1:  nxt = S_ADD2;
      S_ADD2:  nxt = S_ADD3;
      S_NAND1: nxt = S_NAND2;
      S_NAND2: nxt = S_NAND3;
      S_ADDI1: nxt = S_ADDI2;
      S_ADDI2: nxt = S_ADDI3;
      S_LW1:   nxt = S_LW2;
      S_LW2:   nxt = S_LW3;
      S_LW3:   nxt = S_LW4;
      S_SW1:   nxt = S_SW2;
      S_SW2:   nxt = S_SW3;
      S_SW3:   nxt = S_SW4;
      S_BQ1:   nxt = S_BQ2;
      S_BQ2:   nxt = S_BQ3;
      S_BQ3:   nxt = S_BQT;
      S_BQT:   nxt = zero ? S_BQ4 : S_F1;   // microbranch on the latched flag
      S_BQ4:   nxt = S_BQ5;
      S_BQ5:   nxt = S_BQ6;
      S_JR1:   nxt = S_JR2;
      S_HALT:  nxt = S_HALT;
      default: nxt = S_F1;                  // every execute tail returns to fetch
    endcase
  end

endmodule

// File: rtl/microseq_decode.sv
module microseq_decode
  import microseq_pkg::*;
(
  input  mstate_t cur,
  output ctrl_t   ctl,
  output logic    halted
);

  always_comb begin
    ctl    = '0;
    halted = 1'b0;
    case (cur)
      S_F1: begin
        ctl.drv_pc = 1'b1; ctl.ld_mar = 1'b1; ctl.ld_a = 1'b1;
      end
      S_F2: begin
        ctl.drv_mem = 1'b1; ctl.ld_ir = 1'b1;
      end
      S_F3: begin
        ctl.drv_alu = 1'b1; ctl.ld_pc = 1'b1; ctl.alu_fn = FN_INC;
      end
      S_ADD1, S_NAND1, S_ADDI1, S_LW1, S_SW1: begin
        ctl.drv_reg = 1'b1; ctl.ld_a = 1'b1; ctl.reg_sel = SEL_Y;
      end
      S_ADD2, S_NAND2: begin
        ctl.drv_reg = 1'b1; ctl.ld_b = 1'b1; ctl.reg_sel = SEL_Z;
      end
      S_ADDI2, S_LW2, S_SW2, S_BQ5: begin
        ctl.drv_off = 1'b1; ctl.ld_b = 1'b1;
      end
      S_ADD3, S_ADDI3: begin
        ctl.drv_alu = 1'b1; ctl.wr_reg = 1'b1;
        ctl.alu_fn = FN_ADD; ctl.reg_sel = SEL_X;
      end
      S_NAND3: begin
        ctl.drv_alu = 1'b1; ctl.wr_reg = 1'b1;
        ctl.alu_fn = FN_NAND; ctl.reg_sel = SEL_X;
      end
      S_LW3, S_SW3: begin
        ctl.drv_alu = 1'b1; ctl.ld_mar = 1'b1; ctl.alu_fn = FN_ADD;
      end
      S_LW4: begin
        ctl.drv_mem = 1'b1; ctl.wr_reg = 1'b1; ctl.reg_sel = SEL_X;
      end
      S_SW4: begin
        ctl.drv_reg = 1'b1; ctl.wr_mem = 1'b1; ctl.reg_sel = SEL_X;
      end
      S_BQ1: begin
        ctl.drv_reg = 1'b1; ctl.ld_a = 1'b1; ctl.reg_sel = SEL_X;
      end
      S_BQ2: begin
        ctl.drv_reg = 1'b1; ctl.ld_b = 1'b1; ctl.reg_sel = SEL_Y;
      end
      S_BQ3: begin
        ctl.drv_alu = 1'b1; ctl.ld_z = 1'b1; ctl.alu_fn = FN_SUB;
      end
      S_BQT: ;  // idle cycle: flag is now stable for the microbranch
      S_BQ4: begin
        ctl.drv_pc = 1'b1; ctl.ld_a = 1'b1;
      end
      S_BQ6: begin
        ctl.drv_alu = 1'b1; ctl.ld_pc = 1'b1; ctl.alu_fn = FN_ADD;
      end
      S_JR1: begin
        ctl.drv_pc = 1'b1; ctl.wr_reg = 1'b1; ctl.reg_sel = SEL_Y;
      end
      S_JR2: begin
        ctl.drv_reg = 1'b1; ctl.ld_pc = 1'b1; ctl.reg_sel = SEL_X;
      end
      S_HALT: halted = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/microseq_ctrl.sv
module microseq_ctrl
  import microseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             zero,
  output logic             drv_pc,
  output logic             drv_alu,
  output logic             drv_reg,
  output logic             drv_mem,
  output logic             drv_off,
  output logic             ld_pc,
  output logic             ld_a,
  output logic             ld_b,
  output logic             ld_mar,
  output logic             ld_ir,
  output logic             ld_z,
  output logic             wr_mem,
  output logic             wr_reg,
  output logic [FN_W-1:0]  alu_fn,
  output logic [SEL_W-1:0] reg_sel,
  output logic             halted
);

  mstate_t state_q;
  mstate_t state_d;
  ctrl_t   ctl;

  microseq_next u_next (
    .cur    (state_q),
    .opcode (opcode),
    .zero   (zero),
    .nxt    (state_d)
  );

  microseq_decode u_dec (
    .cur    (state_q),
    .ctl    (ctl),
    .halted (halted)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_F1;
    else        state_q <= state_d;
  end

  assign drv_pc  = ctl.drv_pc;
  assign drv_alu = ctl.drv_alu;
  assign drv_reg = ctl.drv_reg;
  assign drv_mem = ctl.drv_mem;
  assign drv_off = ctl.drv_off;
  assign ld_pc   = ctl.ld_pc;
  assign ld_a    = ctl.ld_a;
  assign ld_b    = ctl.ld_b;
  assign ld_mar  = ctl.ld_mar;
  assign ld_ir   = ctl.ld_ir;
  assign ld_z    = ctl.ld_z;
  assign wr_mem  = ctl.wr_mem;
  assign wr_reg  = ctl.wr_reg;
  assign alu_fn  = ctl.alu_fn;
  assign reg_sel = ctl.reg_sel;

  // Shared bus: never two drivers at once.
  assert_one_driver_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_pc, drv_alu, drv_reg, drv_mem, drv_off}));

  // Fetch: F1 is always followed by F2, and F2 by F3.
  assert_fetch_f2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_pc && ld_mar) |=> (drv_mem && ld_ir));
  assert_fetch_f3_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ir |=> (drv_alu && ld_pc && alu_fn == FN_INC));

  // Branch test cycle resolves on the zero flag.
  assert_branch_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ld_z) && !zero) |=> (drv_pc && ld_mar && ld_a));
  assert_branch_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ld_z) && zero) |=> (drv_pc && ld_a && !ld_mar));

  // Store drives Rx onto the bus while writing memory.
  assert_store_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mem |-> (drv_reg && reg_sel == SEL_X && !wr_reg));

  // Halt is sticky until reset.
  assert_halt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !drv_pc && !ld_pc));

endmodule

// File: tb/microseq_ctrl_test.sv
`timescale 1ns/1ps
module microseq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] opcode = 4'd0;
  logic       zero = 1'b0;
  logic drv_pc, drv_alu, drv_reg, drv_mem, drv_off;
  logic ld_pc, ld_a, ld_b, ld_mar, ld_ir, ld_z, wr_mem, wr_reg, halted;
  logic [1:0] alu_fn, reg_sel;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  microseq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .zero(zero),
    .drv_pc(drv_pc), .drv_alu(drv_alu), .drv_reg(drv_reg),
    .drv_mem(drv_mem), .drv_off(drv_off), .ld_pc(ld_pc), .ld_a(ld_a),
    .ld_b(ld_b), .ld_mar(ld_mar), .ld_ir(ld_ir), .ld_z(ld_z),
    .wr_mem(wr_mem), .wr_reg(wr_reg), .alu_fn(alu_fn),
    .reg_sel(reg_sel), .halted(halted)
  );

  // Observed vector layout: halted, 5 drives, 6 loads, wr_mem, wr_reg, fn, sel.
  logic [17:0] obs;
  assign obs = {halted, drv_pc, drv_alu, drv_reg, drv_mem, drv_off,
                ld_pc, ld_a, ld_b, ld_mar, ld_ir, ld_z, wr_mem, wr_reg,
                alu_fn, reg_sel};

  localparam logic [17:0] H    = 18'h1 << 17;
  localparam logic [17:0] DPC  = 18'h1 << 16;
  localparam logic [17:0] DALU = 18'h1 << 15;
  localparam logic [17:0] DREG = 18'h1 << 14;
  localparam logic [17:0] DMEM = 18'h1 << 13;
  localparam logic [17:0] DOFF = 18'h1 << 12;
  localparam logic [17:0] LPC  = 18'h1 << 11;
  localparam logic [17:0] LA   = 18'h1 << 10;
  localparam logic [17:0] LB   = 18'h1 << 9;
  localparam logic [17:0] LMAR = 18'h1 << 8;
  localparam logic [17:0] LIR  = 18'h1 << 7;
  localparam logic [17:0] LZ   = 18'h1 << 6;
  localparam logic [17:0] WMEM = 18'h1 << 5;
  localparam logic [17:0] WREG = 18'h1 << 4;
  localparam logic [17:0] FN1  = 18'h1 << 2;   // alu_fn 01
  localparam logic [17:0] FN2  = 18'h2 << 2;   // alu_fn 10
  localparam logic [17:0] FN3  = 18'h3 << 2;   // alu_fn 11
  localparam logic [17:0] SY   = 18'h1;        // reg_sel 01
  localparam logic [17:0] SZ   = 18'h2;        // reg_sel 10

  localparam logic [17:0] W_F1 = DPC | LMAR | LA;
  localparam logic [17:0] W_F2 = DMEM | LIR;
  localparam logic [17:0] W_F3 = DALU | LPC | FN3;
  localparam logic [17:0] W_RYA = DREG | LA | SY;
  localparam logic [17:0] W_OFB = DOFF | LB;
  localparam logic [17:0] W_AMAR = DALU | LMAR;

  logic [17:0] exp_q[$];
  string       tag_q[$];

  // Scoreboard monitor: mid-cycle compare against the queued expectation.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [17:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (obs !== e) begin
        failures++;
        $display("FAIL %s: ctrl=%05h expected=%05h", t, obs, e);
      end
      checks++;
      if ($countones({drv_pc, drv_alu, drv_reg, drv_mem, drv_off}) > 1) begin
        failures++;
        $display("FAIL R3: drivers=%05b expected at most one",
                 {drv_pc, drv_alu, drv_reg, drv_mem, drv_off});
      end
    end
  end

  // Driver: called at posedge+1 while the design sits in F1.
  task automatic run_instr(input logic [3:0] op, input logic zf,
                           input bit scr, input string tag);
    logic [17:0] seq[$];
    int tst = -1;
    seq.push_back(W_F1); seq.push_back(W_F2); seq.push_back(W_F3);
    case (op)
      4'd0: begin seq.push_back(W_RYA); seq.push_back(DREG | LB | SZ);
                  seq.push_back(DALU | WREG); end
      4'd1: begin seq.push_back(W_RYA); seq.push_back(DREG | LB | SZ);
                  seq.push_back(DALU | WREG | FN1); end
      4'd2: begin seq.push_back(W_RYA); seq.push_back(W_OFB);
                  seq.push_back(DALU | WREG); end
      4'd3: begin seq.push_back(W_RYA); seq.push_back(W_OFB);
                  seq.push_back(W_AMAR); seq.push_back(DMEM | WREG); end
      4'd4: begin seq.push_back(W_RYA); seq.push_back(W_OFB);
                  seq.push_back(W_AMAR); seq.push_back(DREG | WMEM); end
      4'd5: begin
        seq.push_back(DREG | LA); seq.push_back(DREG | LB | SY);
        seq.push_back(DALU | LZ | FN2); seq.push_back(18'h0);
        tst = 6;
        if (zf) begin
          seq.push_back(DPC | LA); seq.push_back(W_OFB);
          seq.push_back(DALU | LPC);
        end
      end
      4'd6: begin seq.push_back(DPC | WREG | SY); seq.push_back(DREG | LPC); end
      4'd7: repeat (5) seq.push_back(H);
      default: ;
    endcase
    for (int i = 0; i < seq.size(); i++) begin
      exp_q.push_back(seq[i]);
      tag_q.push_back(i < 3 ? "R2" : tag);
    end
    for (int i = 0; i < seq.size(); i++) begin
      opcode = (i == 2 || !scr) ? op : ~op;
      zero   = (i == tst || !scr) ? zf : ~zf;
      @(posedge clk); #1;
    end
  endtask

  task automatic check_reset(input string tag);
    checks++;
    if (obs !== W_F1) begin
      failures++;
      $display("FAIL %s: ctrl=%05h expected=%05h", tag, obs, W_F1);
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: run did not finish expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_reset("R1");
    rst_n = 1'b1;
    run_instr(4'd0, 1'b0, 1'b0, "R4");   // add
    run_instr(4'd1, 1'b0, 1'b0, "R4");   // nand
    run_instr(4'd2, 1'b0, 1'b0, "R5");
    run_instr(4'd3, 1'b0, 1'b0, "R6");
    run_instr(4'd4, 1'b0, 1'b0, "R7");
    run_instr(4'd5, 1'b0, 1'b0, "R8");
    run_instr(4'd5, 1'b1, 1'b0, "R9");
    run_instr(4'd6, 1'b0, 1'b0, "R10");
    run_instr(4'd8, 1'b0, 1'b0, "R12");
    run_instr(4'd15, 1'b0, 1'b0, "R12");
    run_instr(4'd4, 1'b0, 1'b0, "R7");   // store right after a no-op
    // R13: inputs scrambled outside their decision edges.
    run_instr(4'd0, 1'b1, 1'b1, "R13");
    run_instr(4'd5, 1'b1, 1'b1, "R13");
    run_instr(4'd5, 1'b0, 1'b1, "R13");
    run_instr(4'd3, 1'b0, 1'b1, "R13");
    run_instr(4'd6, 1'b1, 1'b1, "R13");
    run_instr(4'd7, 1'b0, 1'b1, "R11");  // halt, then junk inputs
    rst_n = 1'b0;
    #1;
    check_reset("R11");
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    run_instr(4'd1, 1'b0, 1'b0, "R11");  // runs again after reset
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule